// File: doc/BRIEF.md
# Sound RAM DMA Port with IRQ Address Match

This block sits between one host DMA channel and the local sample memory of one sound processor core, moving 16-bit words in either direction. Software loads a transfer address, then pulses a start strobe with a direction and a word count. In the read direction the block fetches consecutive memory words through a synchronous RAM port and hands them to the host as a valid/ready stream. In the write direction it accepts host words from a valid/ready stream and stores them at consecutive addresses. One instance is built per core; the `CORE` parameter selects the write wrap window and the bit positions of the per-core flags.

While a transfer runs, a programmed IRQ address is compared with the memory addresses being touched. When the interrupt-enable control bit is set and a match is found, a per-core IRQ flag is raised and a one-cycle IRQ pulse is issued. The two directions treat the final address differently. A read leaves a fixed tail offset after its last word. A write folds an address that has left the core's window back to the window base. At the end of every transfer a per-core completion-pending bit is set. The DMA-ready status bit drops when a transfer starts and returns when software acknowledges the completion. The acknowledge also clears two mode bits of the control register.

Top module: `sdma_port`

## Requirements
- R1: In a read transfer the host receives, in order, the words at addresses start, start+1, ... (one per accepted beat), the address advancing modulo 2^20 so that 0xFFFFF is followed by 0x00000.
- R2: After a read transfer of N words, the transfer address equals (start + N + 19) modulo 2^20.
- R3: In a write transfer, the k-th accepted host word (k from 0) is written to RAM address start+k with write enable high, and a RAM write happens only on an accepted host beat.
- R4: After a write transfer of N words, the transfer address is start+N, except that it becomes the window base when start+N exceeds the window top; the window is 0x2000..0x23FF for core 0 and 0x2400..0x27FF for core 1.
- R5: In a read with control bit 6 set, reading the word at the IRQ address sets IRQ flag bit 2 (core 0) or bit 3 (core 1) and gives exactly one one-cycle IRQ pulse; with control bit 6 clear neither happens.
- R6: A write started with control bit 6 set raises the same flag and pulse once when the IRQ address lies in the inclusive range start..start+N, compared without wrap; otherwise neither happens.
- R7: The IRQ flag stays set until the IRQ clear input is pulsed; a new match in the same cycle as the clear keeps it set.
- R8: Accepting a transfer start clears the DMA-ready status bit.
- R9: The completion acknowledge sets DMA-ready, clears control bits 5:4 and keeps the other control bits, and clears the completion-pending bit; if a start is accepted in the same cycle, DMA-ready ends up clear.
- R10: When a transfer ends, completion-pending bit 1 (core 0) or bit 2 (core 1) is set and the block is idle again.
- R11: A start strobe or a transfer-address write that arrives while a transfer is active is ignored, and no RAM access occurs while idle.
- R12: After reset the transfer address and control register are zero, DMA-ready is one, all flags are zero and both stream sides are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| taddr_we | input | 1 | Load the transfer address (idle only) |
| taddr_wdata | input | ADDR_W | New transfer address |
| taddr | output | ADDR_W | Current transfer address |
| irq_addr | input | ADDR_W | Address that raises the IRQ when accessed |
| ctrl_we | input | 1 | Write the control register |
| ctrl_wdata | input | 16 | New control value (bit 6 is IRQ enable) |
| ctrl_q | output | 16 | Control register |
| xfer_start | input | 1 | Start pulse |
| xfer_rd | input | 1 | Direction at start: 1 memory to host, 0 host to memory |
| xfer_len | input | CNT_W | Word count at start |
| hw_valid | input | 1 | Host write word valid |
| hw_data | input | DATA_W | Host write word |
| hw_ready | output | 1 | Block accepts a host write word |
| hr_valid | output | 1 | Host read word valid |
| hr_data | output | DATA_W | Host read word |
| hr_ready | input | 1 | Host takes the read word |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, one cycle after the access |
| done_ack | input | 1 | Acknowledge of the completion interrupt |
| irq_clr | input | 1 | Clear the IRQ flag |
| dma_rdy | output | 1 | DMA-ready status bit |
| irq_info | output | 4 | IRQ flags, only the core's own bit is used |
| irq_pulse | output | 1 | One-cycle pulse per IRQ match |
| evt_pend | output | 3 | Completion-pending bits, only the core's own bit is used |

## Verification
The acknowledge of a finished transfer and the start of the next one can fall in the same cycle, and both write the DMA-ready bit and the pending bit. The bench leaves a transfer unacknowledged, then drives the acknowledge and a new start strobe on the same clock edge. It expects DMA-ready to stay clear, control bits 5:4 to be cleared and the old pending bit to be gone until the new transfer sets it again. Address and IRQ outcomes are swept over many start addresses, lengths and IRQ positions around the range ends, with the two wrap points and the window edges as the start values.

// File: rtl/sdma_pkg.sv
// Shared definitions for the sound RAM DMA port.
// Assumes a 16-bit control register with the IRQ enable at bit 6 and
// the transfer mode field at bits 5:4.
package sdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sdma_state_e;

    localparam int CTRL_W      = 16;
    localparam int CTRL_IRQ_EN = 6;
    localparam int CTRL_MODE_H = 5;
    localparam int CTRL_MODE_L = 4;
    localparam int READ_TAIL   = 19;
    localparam int IRQ_BIT0    = 2;
    localparam int PEND_BIT0   = 1;
endpackage

// File: rtl/sdma_addr_gen.sv
// Transfer address register with the direction-specific end rules.
// Assumes load, step and the two finish strobes are mutually exclusive
// by the caller's sequencing; load has priority if they are not.
module sdma_addr_gen #(
    parameter int ADDR_W = 20,
    parameter logic [ADDR_W-1:0] WIN_LO = '0,
    parameter logic [ADDR_W-1:0] WIN_HI = '1,
    parameter int TAIL = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              step,
    input  logic              fin_rd,
    input  logic              fin_wr,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] TAIL_V = ADDR_W'(TAIL);

    // Purpose: hold, advance and fold the transfer address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (ld) begin
            addr <= ld_val;
        end else if (step) begin
            addr <= addr + 1'b1;
        end else if (fin_rd) begin
            addr <= addr + TAIL_V;
        end else if (fin_wr && (addr > WIN_HI)) begin
            addr <= WIN_LO;
        end
    end
endmodule

// File: rtl/sdma_irq_det.sv
// IRQ address comparator. A point check compares one accessed address;
// a range check covers base..base+len inclusive without wrap.
// Assumes the strobes are single-cycle; the hit output is registered.
module sdma_irq_det #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] irq_addr,
    input  logic              pt_chk,
    input  logic [ADDR_W-1:0] pt_addr,
    input  logic              rng_chk,
    input  logic [ADDR_W-1:0] rng_base,
    input  logic [CNT_W-1:0]  rng_len,
    output logic              hit
);
    localparam int SUM_W = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 1;

    logic [SUM_W-1:0] rng_end;
    logic             in_rng;
    logic             pt_eq;

    // Purpose: form the range end and both compare results.
    always_comb begin
        rng_end = SUM_W'(rng_base) + SUM_W'(rng_len);
        in_rng  = (SUM_W'(irq_addr) >= SUM_W'(rng_base)) &&
                  (SUM_W'(irq_addr) <= rng_end);
        pt_eq   = (pt_addr == irq_addr);
    end

    // Purpose: register a one-cycle hit when an enabled check matches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit <= 1'b0;
        end else begin
            hit <= en && ((pt_chk && pt_eq) || (rng_chk && in_rng));
        end
    end
endmodule

// File: rtl/sdma_rd_buf.sv
// Two-entry buffer for words returned by the synchronous RAM.
// Assumes the caller never pushes into a full buffer and never pops
// an empty one.
module sdma_rd_buf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] data,
    output logic [1:0]   level
);
    logic [W-1:0] q0;
    logic [W-1:0] q1;

    // Purpose: keep the oldest word in q0 and count occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0    <= '0;
            q1    <= '0;
            level <= 2'd0;
        end else begin
            case ({push, pop})
                2'b10: begin
                    if (level == 2'd0) q0 <= push_data;
                    else               q1 <= push_data;
                    level <= level + 2'd1;
                end
                2'b01: begin
                    q0    <= q1;
                    level <= level - 2'd1;
                end
                2'b11: begin
                    if (level == 2'd1) begin
                        q0 <= push_data;
                    end else begin
                        q0 <= q1;
                        q1 <= push_data;
                    end
                end
                default: ;
            endcase
        end
    end

    assign valid = (level != 2'd0);
    assign data  = q0;
endmodule

// File: rtl/sdma_ctl_stat.sv
// Control register, DMA-ready status, IRQ flag and completion-pending
// bit for one core. Assumes CORE is 0 or 1.
module sdma_ctl_stat
    import sdma_pkg::*;
#(
    parameter int CORE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              ack,
    input  logic              start_acc,
    input  logic              hit,
    input  logic              irq_clr,
    input  logic              done_evt,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              dma_rdy,
    output logic [3:0]        irq_info,
    output logic [2:0]        evt_pend
);
    localparam int IB = IRQ_BIT0 + CORE;
    localparam int PB = PEND_BIT0 + CORE;

    logic [CTRL_W-1:0] ctrl_nx;
    logic              flag_q;
    logic              pend_q;

    // Purpose: merge a software write with the acknowledge's mode clear.
    always_comb begin
        ctrl_nx = ctrl_we ? ctrl_wdata : ctrl_q;
        if (ack) ctrl_nx[CTRL_MODE_H:CTRL_MODE_L] = '0;
    end

    // Purpose: update control, ready, IRQ flag and pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            dma_rdy <= 1'b1;
            flag_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_nx;
            if (start_acc)  dma_rdy <= 1'b0;
            else if (ack)   dma_rdy <= 1'b1;
            if (hit)          flag_q <= 1'b1;
            else if (irq_clr) flag_q <= 1'b0;
            if (done_evt) pend_q <= 1'b1;
            else if (ack) pend_q <= 1'b0;
        end
    end

    // Purpose: place the per-core bits in the shared flag words.
    always_comb begin
        irq_info     = '0;
        irq_info[IB] = flag_q;
        evt_pend     = '0;
        evt_pend[PB] = pend_q;
    end
endmodule

// File: rtl/sdma_port.sv
// Sound RAM DMA port for one core: sequences read and write transfers
// between host word streams and a synchronous RAM (one-cycle read
// latency), with IRQ address matching and status handling.
// Assumes ADDR_W >= 14 so both core windows fit.
module sdma_port
    import sdma_pkg::*;
#(
    parameter int CORE     = 0,
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 16,
    parameter int WIN_BASE = 'h2000,
    parameter int WIN_SPAN = 'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              taddr_we,
    input  logic [ADDR_W-1:0] taddr_wdata,
    output logic [ADDR_W-1:0] taddr,
    input  logic [ADDR_W-1:0] irq_addr,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic              xfer_start,
    input  logic              xfer_rd,
    input  logic [CNT_W-1:0]  xfer_len,
    input  logic              hw_valid,
    input  logic [DATA_W-1:0] hw_data,
    output logic              hw_ready,
    output logic              hr_valid,
    output logic [DATA_W-1:0] hr_data,
    input  logic              hr_ready,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              done_ack,
    input  logic              irq_clr,
    output logic              dma_rdy,
    output logic [3:0]        irq_info,
    output logic              irq_pulse,
    output logic [2:0]        evt_pend
);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE + CORE * WIN_SPAN);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_BASE + (CORE + 1) * WIN_SPAN - 1);

    sdma_state_e      state;
    logic             dir_rd;
    logic [CNT_W-1:0] rem;
    logic             rd_inflight;
    logic             busy;
    logic             start_acc;
    logic             wr_fire;
    logic             rd_issue;
    logic             rd_pop;
    logic             run_done;
    logic [1:0]       buf_level;
    logic [1:0]       occ;
    logic             addr_ld;
    logic             hit;

    // Purpose: derive handshakes, RAM strobes and the end-of-run test.
    always_comb begin
        busy      = (state != ST_IDLE);
        start_acc = (state == ST_IDLE) && xfer_start;
        addr_ld   = (state == ST_IDLE) && taddr_we && !xfer_start;
        hw_ready  = (state == ST_RUN) && !dir_rd && (rem != '0);
        wr_fire   = hw_ready && hw_valid;
        rd_pop    = hr_valid && hr_ready;
        occ       = buf_level + {1'b0, rd_inflight};
        rd_issue  = (state == ST_RUN) && dir_rd && (rem != '0) &&
                    ((occ < 2'd2) || rd_pop);
        run_done  = (state == ST_RUN) && (rem == '0) &&
                    (!dir_rd || (!rd_inflight && !hr_valid));
        ram_en    = wr_fire || rd_issue;
        ram_we    = wr_fire;
        ram_addr  = taddr;
        ram_wdata = hw_data;
    end

    // Purpose: transfer sequencer and remaining-word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            dir_rd      <= 1'b0;
            rem         <= '0;
            rd_inflight <= 1'b0;
        end else begin
            rd_inflight <= rd_issue;
            case (state)
                ST_IDLE: if (start_acc) begin
                    state  <= ST_RUN;
                    dir_rd <= xfer_rd;
                    rem    <= xfer_len;
                end
                ST_RUN: begin
                    if (wr_fire || rd_issue) rem <= rem - 1'b1;
                    if (run_done) state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    sdma_addr_gen #(
        .ADDR_W (ADDR_W),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI),
        .TAIL   (READ_TAIL)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (addr_ld),
        .ld_val (taddr_wdata),
        .step   (wr_fire || rd_issue),
        .fin_rd ((state == ST_FIN) && dir_rd),
        .fin_wr ((state == ST_FIN) && !dir_rd),
        .addr   (taddr)
    );

    sdma_irq_det #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl_q[CTRL_IRQ_EN]),
        .irq_addr (irq_addr),
        .pt_chk   (rd_issue),
        .pt_addr  (taddr),
        .rng_chk  (start_acc && !xfer_rd),
        .rng_base (taddr),
        .rng_len  (xfer_len),
        .hit      (hit)
    );

    sdma_rd_buf #(
        .W (DATA_W)
    ) u_rbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rd_inflight),
        .push_data (ram_rdata),
        .pop       (rd_pop),
        .valid     (hr_valid),
        .data      (hr_data),
        .level     (buf_level)
    );

    sdma_ctl_stat #(
        .CORE (CORE)
    ) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ack        (done_ack),
        .start_acc  (start_acc),
        .hit        (hit),
        .irq_clr    (irq_clr),
        .done_evt   (state == ST_FIN),
        .ctrl_q     (ctrl_q),
        .dma_rdy    (dma_rdy),
        .irq_info   (irq_info),
        .evt_pend   (evt_pend)
    );

    assign irq_pulse = hit;
endmodule

// File: rtl/sdma_port_chk.sv
// Property checker for sdma_port, attached by bind below.
// Assumes busy reflects a non-idle sequencer.
module sdma_port_chk #(
    parameter int CORE = 0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        xfer_start,
    input logic        busy,
    input logic        done_ack,
    input logic        dma_rdy,
    input logic [15:0] ctrl_q,
    input logic        irq_pulse,
    input logic [3:0]  irq_info,
    input logic [2:0]  evt_pend,
    input logic        ram_en,
    input logic        ram_we,
    input logic        hw_valid,
    input logic        hw_ready
);
    a_r8_start_clears_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !busy) |=> !dma_rdy);

    a_r9_ack_sets_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ack && !(xfer_start && !busy)) |=> dma_rdy);

    a_r9_ack_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
        done_ack |=> (ctrl_q[5:4] == 2'b00));

    a_r5_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> irq_info[2+CORE]);

    a_r10_pend_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_pend[1+CORE]) |-> !busy);

    a_r3_write_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && ram_we) |-> (hw_valid && hw_ready));

    a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ram_en);
endmodule

bind sdma_port sdma_port_chk #(.CORE(CORE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .busy       (busy),
    .done_ack   (done_ack),
    .dma_rdy    (dma_rdy),
    .ctrl_q     (ctrl_q),
    .irq_pulse  (irq_pulse),
    .irq_info   (irq_info),
    .evt_pend   (evt_pend),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .hw_valid   (hw_valid),
    .hw_ready   (hw_ready)
);

// File: tb/sdma_port_bench.sv
// Bench: two instances (core 0 and core 1) share all stimulus; sweeps
// start addresses, lengths and IRQ positions with computed expectations.
module sdma_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        taddr_we = 1'b0;
    logic [19:0] taddr_wdata = '0;
    logic [19:0] irq_addr = '0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        xfer_start = 1'b0;
    logic        xfer_rd = 1'b0;
    logic [15:0] xfer_len = '0;
    logic        hw_valid = 1'b0;
    logic [15:0] hw_data = '0;
    logic        hr_ready = 1'b0;
    logic [15:0] ram_rdata = '0;
    logic        done_ack = 1'b0;
    logic        irq_clr = 1'b0;

    logic [19:0] taddr, c1_taddr, ram_addr, c1_ram_addr;
    logic [15:0] ctrl_q, c1_ctrl_q, hr_data, c1_hr_data, ram_wdata, c1_ram_wdata;
    logic        hw_ready, c1_hw_ready, hr_valid, c1_hr_valid;
    logic        ram_en, c1_ram_en, ram_we, c1_ram_we;
    logic        dma_rdy, c1_dma_rdy, irq_pulse, c1_irq_pulse;
    logic [3:0]  irq_info, c1_irq_info;
    logic [2:0]  evt_pend, c1_evt_pend;

    int total = 0;
    int bad = 0;
    int pc0 = 0;
    int pc1 = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sdma_port #(.CORE(0)) u_sdma_port (
        .clk(clk), .rst_n(rst_n), .taddr_we(taddr_we), .taddr_wdata(taddr_wdata),
        .taddr(taddr), .irq_addr(irq_addr), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .xfer_start(xfer_start), .xfer_rd(xfer_rd), .xfer_len(xfer_len),
        .hw_valid(hw_valid), .hw_data(hw_data), .hw_ready(hw_ready),
        .hr_valid(hr_valid), .hr_data(hr_data), .hr_ready(hr_ready),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .done_ack(done_ack), .irq_clr(irq_clr),
        .dma_rdy(dma_rdy), .irq_info(irq_info), .irq_pulse(irq_pulse), .evt_pend(evt_pend));

    sdma_port #(.CORE(1)) u_sdma_port_c1 (
        .clk(clk), .rst_n(rst_n), .taddr_we(taddr_we), .taddr_wdata(taddr_wdata),
        .taddr(c1_taddr), .irq_addr(irq_addr), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(c1_ctrl_q), .xfer_start(xfer_start), .xfer_rd(xfer_rd), .xfer_len(xfer_len),
        .hw_valid(hw_valid), .hw_data(hw_data), .hw_ready(c1_hw_ready),
        .hr_valid(c1_hr_valid), .hr_data(c1_hr_data), .hr_ready(hr_ready),
        .ram_en(c1_ram_en), .ram_we(c1_ram_we), .ram_addr(c1_ram_addr), .ram_wdata(c1_ram_wdata),
        .ram_rdata(ram_rdata), .done_ack(done_ack), .irq_clr(irq_clr),
        .dma_rdy(c1_dma_rdy), .irq_info(c1_irq_info), .irq_pulse(c1_irq_pulse),
        .evt_pend(c1_evt_pend));

    function automatic logic [15:0] rf(logic [19:0] a);
        return a[15:0] ^ {a[19:16], 12'h5C3};
    endfunction

    // RAM model: content is a fixed function of the address.
    always_ff @(posedge clk) begin
        if (ram_en && !ram_we) ram_rdata <= rf(ram_addr);
    end

    always @(posedge clk) begin
        if (irq_pulse) pc0 = pc0 + 1;
        if (c1_irq_pulse) pc1 = pc1 + 1;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic setup(logic [19:0] st, logic [19:0] ia, bit en);
        @(negedge clk);
        taddr_we = 1'b1; taddr_wdata = st;
        ctrl_we = 1'b1; ctrl_wdata = en ? 16'h0070 : 16'h0030;
        irq_addr = ia;
        @(negedge clk);
        taddr_we = 1'b0; ctrl_we = 1'b0;
    endtask

    task automatic wait_done();
        while (!evt_pend[1]) @(negedge clk);
    endtask

    // Checks after a transfer, then acknowledge and IRQ clear.
    task automatic post(logic [19:0] ea0, logic [19:0] ea1, bit hit, bit en,
                        int p0, int p1);
        check("R10 pend c0", 32'(evt_pend), 32'h2);
        check("R10 pend c1", 32'(c1_evt_pend), 32'h4);
        check("R8 ready low", 32'(dma_rdy), 32'h0);
        check("R2/R4 addr c0", 32'(taddr), 32'(ea0));
        check("R2/R4 addr c1", 32'(c1_taddr), 32'(ea1));
        check("R5/R6 flag c0", 32'(irq_info), hit ? 32'h4 : 32'h0);
        check("R5/R6 flag c1", 32'(c1_irq_info), hit ? 32'h8 : 32'h0);
        check("R5/R6 pulses c0", 32'(pc0 - p0), hit ? 32'd1 : 32'd0);
        check("R5/R6 pulses c1", 32'(pc1 - p1), hit ? 32'd1 : 32'd0);
        @(negedge clk); done_ack = 1'b1;
        @(negedge clk); done_ack = 1'b0;
        check("R9 ready set", 32'(dma_rdy), 32'h1);
        check("R9 ctrl mode clear", 32'(ctrl_q), en ? 32'h40 : 32'h0);
        check("R9 pend clear", 32'(evt_pend), 32'h0);
        check("R7 flag held", 32'(irq_info), hit ? 32'h4 : 32'h0);
        irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check("R7 flag cleared", 32'(irq_info | c1_irq_info), 32'h0);
    endtask

    task automatic run_write(logic [19:0] st, int len, logic [19:0] ia, bit en);
        int i = 0;
        int g = 0;
        int p0, p1;
        logic [20:0] e;
        logic [19:0] ea0, ea1;
        bit hit;
        setup(st, ia, en);
        p0 = pc0; p1 = pc1;
        @(negedge clk); xfer_start = 1'b1; xfer_rd = 1'b0; xfer_len = 16'(len);
        @(negedge clk); xfer_start = 1'b0;
        while (i < len) begin
            hw_valid = ((g % 3) != 2);
            hw_data = 16'((st + 20'(i)) ^ 20'h3C5A);
            g++;
            #1;
            if (hw_valid && hw_ready) begin
                check("R3 write strobe", {30'd0, ram_en, ram_we}, 32'h3);
                check("R3 write addr", 32'(ram_addr), 32'(st + 20'(i)));
                check("R3 write data", 32'(ram_wdata), 32'(hw_data));
                i++;
            end
            @(negedge clk);
        end
        hw_valid = 1'b0;
        wait_done();
        e = 21'(st) + 21'(len);
        ea0 = (e > 21'h23FF) ? 20'h2000 : e[19:0];
        ea1 = (e > 21'h27FF) ? 20'h2400 : e[19:0];
        hit = en && (ia >= st) && (21'(ia) <= e);
        post(ea0, ea1, hit, en, p0, p1);
    endtask

    task automatic run_read(logic [19:0] st, int len, logic [19:0] ia, bit en);
        int j = 0;
        int k = 0;
        int p0, p1;
        logic [19:0] d;
        logic [19:0] ea;
        bit hit;
        setup(st, ia, en);
        p0 = pc0; p1 = pc1;
        @(negedge clk); xfer_start = 1'b1; xfer_rd = 1'b1; xfer_len = 16'(len);
        @(negedge clk); xfer_start = 1'b0;
        while (j < len) begin
            hr_ready = ((k % 3) != 1);
            k++;
            #1;
            if (hr_valid && hr_ready) begin
                check("R1 read data c0", 32'(hr_data), 32'(rf(st + 20'(j))));
                check("R1 read data c1", 32'(c1_hr_data), 32'(rf(st + 20'(j))));
                j++;
            end
            @(negedge clk);
        end
        hr_ready = 1'b0;
        wait_done();
        d = ia - st;
        hit = en && (32'(d) < 32'(len));
        ea = st + 20'(len) + 20'd19;
        post(ea, ea, hit, en, p0, p1);
    endtask

    initial begin
        logic [19:0] wst [5];
        logic [19:0] rst_list [3];
        wst[0] = 20'h02000; wst[1] = 20'h023FC; wst[2] = 20'h023FD;
        wst[3] = 20'h00100; wst[4] = 20'h027FD;
        rst_list[0] = 20'h00010; rst_list[1] = 20'hFFFFD; rst_list[2] = 20'hFFFFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check("R12 addr", 32'(taddr), 32'h0);
        check("R12 ctrl", 32'(ctrl_q), 32'h0);
        check("R12 ready", 32'(dma_rdy), 32'h1);
        check("R12 flags", {25'd0, irq_info, evt_pend}, 32'h0);
        check("R12 streams", {29'd0, hw_ready, hr_valid, ram_en}, 32'h0);

        for (int s = 0; s < 5; s++)
            for (int len = 0; len <= 5; len++)
                for (int off = -1; off <= len + 1; off++)
                    for (int en = 0; en < 2; en++)
                        run_write(wst[s], len, wst[s] + 20'(off), en[0]);

        for (int s = 0; s < 3; s++)
            for (int len = 0; len <= 5; len++)
                for (int off = -1; off <= len + 1; off++)
                    for (int en = 0; en < 2; en++)
                        run_read(rst_list[s], len, rst_list[s] + 20'(off), en[0]);

        // R9: acknowledge and new start in the same cycle
        setup(20'h00100, 20'h0, 1'b0);
        @(negedge clk); xfer_start = 1'b1; xfer_rd = 1'b0; xfer_len = 16'd0;
        @(negedge clk); xfer_start = 1'b0;
        wait_done();
        check("R8 ready after run", 32'(dma_rdy), 32'h0);
        @(negedge clk); xfer_start = 1'b1; done_ack = 1'b1;
        @(negedge clk); xfer_start = 1'b0; done_ack = 1'b0;
        check("R9 start wins ready", 32'(dma_rdy), 32'h0);
        check("R9 same-cycle mode clear", 32'(ctrl_q[5:4]), 32'h0);
        check("R9 same-cycle pend clear", 32'(evt_pend), 32'h0);
        wait_done();
        check("R10 pend again", 32'(evt_pend), 32'h2);
        @(negedge clk); done_ack = 1'b1;
        @(negedge clk); done_ack = 1'b0;
        check("R9 ready restored", 32'(dma_rdy), 32'h1);

        // R11: start and address write while a read is active
        setup(20'h00040, 20'h0, 1'b0);
        @(negedge clk); xfer_start = 1'b1; xfer_rd = 1'b1; xfer_len = 16'd5;
        @(negedge clk); xfer_start = 1'b0;
        @(negedge clk); xfer_start = 1'b1; xfer_len = 16'd2;
        taddr_we = 1'b1; taddr_wdata = 20'h00999;
        @(negedge clk); xfer_start = 1'b0; taddr_we = 1'b0;
        begin
            int j = 0;
            while (j < 5) begin
                hr_ready = 1'b1;
                #1;
                if (hr_valid) begin
                    check("R11 data kept", 32'(hr_data), 32'(rf(20'h00040 + 20'(j))));
                    j++;
                end
                @(negedge clk);
            end
            hr_ready = 1'b0;
        end
        wait_done();
        check("R11 addr unaffected", 32'(taddr), 32'(20'h00040 + 20'd24));
        check("R11 idle no access", 32'(ram_en), 32'h0);
        @(negedge clk); done_ack = 1'b1;
        @(negedge clk); done_ack = 1'b0;

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule